// File: doc/BRIEF.md
# Banked RAM Overlay Controller

This block places a RAM overlay over the top 12 KB of an 8-bit CPU's 64 KB address space, from page 0xD0 up to page 0xFF. A set of soft switches at sixteen offsets of an I/O window controls the overlay. Reading or writing a switch offset chooses one of two 4 KB banks for pages 0xD0–0xDF. The same access decides whether CPU reads in the overlay range come from the internal RAM or from an external ROM, and whether CPU writes land in RAM or are dropped. Pages 0xE0–0xFF always map to one 8 KB region that both banks share.

RAM writes are protected by a two-step arming rule. A write-enabling switch must be read twice in a row before writes reach RAM. Any write access to such a switch disarms the sequence, and so does a switch that turns writes off. Two status offsets report the bank choice and the read source in bit 7.

Each RAM region keeps the low `LINE_BITS` bits of the address; the higher bits alias. A value of 12 gives the full 4 KB + 4 KB + 8 KB. The smaller default keeps the storage compact.

Top module: `ovl_ctrl`

## Requirements
- R1: After reset, RAM reads and RAM writes are disabled, bank 1 is selected and the arming latch is clear. Both status offsets return 0x00, and a CPU read in the overlay range returns ROM data.
- R2: Every switch access sets the bank choice from offset bit 3, for a read or a write access: 0 selects bank 2 and 1 selects bank 1. Offset bit 2 has no effect, so 0x4–0x7 behave as 0x0–0x3 and 0xC–0xF behave as 0x8–0xB.
- R3: A switch access with low bits 00 enables RAM reads. Low bits 10 disable RAM reads. Both codes disable RAM writes and clear the arming latch.
- R4: A read access with low bits 01 disables RAM reads, and one with low bits 11 enables them. For both codes the write enable takes the arming latch's previous value and the latch is then set, so two consecutive such reads enable RAM writes.
- R5: A write access with low bits 01 or 11 leaves the write enable as it was and clears the arming latch. It sets the read source in the same way as a read access.
- R6: A status read at offset 0x1 returns 0x80 when bank 2 is selected, else 0x00. At offset 0x2 it returns 0x80 when RAM reads are enabled, else 0x00. Any other status offset returns 0x00. Status reads change no state, and switch accesses return 0x00.
- R7: CPU accesses to pages 0xD0–0xDF use the selected bank, and data written in one bank is not visible in the other at the same address.
- R8: CPU accesses to pages 0xE0–0xFF use the common region, whichever bank is selected.
- R9: With RAM reads disabled, reads in pages 0xD0–0xFF return ROM data. With RAM writes disabled, writes there leave the RAM unchanged. With reads disabled and writes enabled, writes still reach RAM.
- R10: A CPU read in pages 0xD0–0xFF raises `cpu_rvalid` for one cycle, in the cycle after the request, with the data on `cpu_rdata`. Reads below 0xD000 and all CPU writes raise no `cpu_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | CPU memory access strobe |
| cpu_wr | input | 1 | 1 = CPU write, 0 = CPU read |
| cpu_addr | input | 16 | CPU address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Read data, valid with cpu_rvalid |
| cpu_rvalid | output | 1 | One-cycle pulse after an overlay-range read |
| rom_addr | output | 16 | ROM read address |
| rom_re | output | 1 | ROM read request |
| rom_rdata | input | 8 | ROM data, one cycle after rom_re |
| sw_sel | input | 1 | Soft-switch access strobe |
| stat_sel | input | 1 | Status read strobe |
| sw_wr | input | 1 | 1 = write access to a switch or status offset |
| sw_off | input | 4 | Switch or status offset |
| sw_rdata | output | 8 | Status read result, combinational |

## Verification
The hardest condition to reach is a disarmed write enable that follows an armed one. The stimulus first arms the overlay and writes known bytes. It then breaks the double-read sequence, once with a write access to a switch and once with a write-disabling switch. A write that should be dropped goes to a location already holding a known byte, and that location is read back after re-arming. The read-from-ROM, write-to-RAM combination is reached by two reads of a 01-code switch, and the write is confirmed after RAM reads are switched back on.

// File: rtl/ovl_ctrl.sv
module ovl_ctrl #(
  parameter int LINE_BITS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cpu_req,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_addr,
  input  logic [7:0]  cpu_wdata,
  output logic [7:0]  cpu_rdata,
  output logic        cpu_rvalid,
  output logic [15:0] rom_addr,
  output logic        rom_re,
  input  logic [7:0]  rom_rdata,
  input  logic        sw_sel,
  input  logic        stat_sel,
  input  logic        sw_wr,
  input  logic [3:0]  sw_off,
  output logic [7:0]  sw_rdata
);

  localparam int DEPTH = 4 << LINE_BITS;
  localparam int IDX_W = LINE_BITS + 2;

  logic rd_en_q, wr_en_q, bank2_q, pre_q;
  logic rvalid_q, from_ram_q;
  logic [7:0] ram_q;
  logic [7:0] mem [DEPTH];

  logic       in_win;
  logic [1:0] region;
  logic [IDX_W-1:0] idx;
  logic       ram_we;

  assign in_win = cpu_req && (cpu_addr[15:12] >= 4'hD);
  assign region = cpu_addr[13] ? {1'b1, cpu_addr[12]} : {1'b0, bank2_q};
  assign idx    = {region, cpu_addr[LINE_BITS-1:0]};
  assign ram_we = in_win && cpu_wr && wr_en_q;

  assign rom_addr   = cpu_addr;
  assign rom_re     = in_win && !cpu_wr && !rd_en_q;
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = from_ram_q ? ram_q : rom_rdata;

  always_ff @(posedge clk) begin
    if (ram_we) mem[idx] <= cpu_wdata;
    ram_q <= mem[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q   <= 1'b0;
      from_ram_q <= 1'b0;
    end else begin
      rvalid_q   <= in_win && !cpu_wr;
      from_ram_q <= rd_en_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_en_q <= 1'b0;
      wr_en_q <= 1'b0;
      bank2_q <= 1'b0;
      pre_q   <= 1'b0;
    end else if (sw_sel) begin
      bank2_q <= !sw_off[3];
      case (sw_off[1:0])
        2'b00: begin rd_en_q <= 1'b1; wr_en_q <= 1'b0; pre_q <= 1'b0; end
        2'b10: begin rd_en_q <= 1'b0; wr_en_q <= 1'b0; pre_q <= 1'b0; end
        default: begin
          rd_en_q <= sw_off[1];
          if (!sw_wr) wr_en_q <= pre_q;
          pre_q <= !sw_wr;
        end
      endcase
    end
  end

  always_comb begin
    sw_rdata = 8'h00;
    if (stat_sel && !sw_sel && !sw_wr) begin
      if (sw_off == 4'h1) sw_rdata = {bank2_q, 7'b0};
      else if (sw_off == 4'h2) sw_rdata = {rd_en_q, 7'b0};
    end
  end

  a_r3_disarm: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel && !sw_off[0] |=> !wr_en_q && !pre_q);

  a_r4_arm: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel && sw_off[0] && !sw_wr |=> (wr_en_q == $past(pre_q)) && pre_q);

  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel && sw_off[0] && sw_wr |=> $stable(wr_en_q) && !pre_q);

  a_r2_bank: assert property (@(posedge clk) disable iff (!rst_n)
    sw_sel |=> bank2_q != $past(sw_off[3]));

  a_r6_stat_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stat_sel && !sw_sel |=> $stable(rd_en_q) && $stable(wr_en_q) && $stable(bank2_q) && $stable(pre_q));

  a_r10_valid: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid |-> $past(cpu_req && !cpu_wr));

  a_r9_rom_path: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rvalid && !$past(rd_en_q) |-> cpu_rdata == rom_rdata);

endmodule

// File: tb/ovl_ctrl_bench.sv
module ovl_ctrl_bench;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cpu_req = 0, cpu_wr = 0;
  logic [15:0] cpu_addr = 0;
  logic [7:0] cpu_wdata = 0, cpu_rdata, rom_rdata = 0, sw_rdata;
  logic cpu_rvalid, rom_re, sw_sel = 0, stat_sel = 0, sw_wr = 0;
  logic [15:0] rom_addr;
  logic [3:0] sw_off = 0;

  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovl_ctrl u_ovl_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_wr(cpu_wr),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .cpu_rvalid(cpu_rvalid), .rom_addr(rom_addr), .rom_re(rom_re),
    .rom_rdata(rom_rdata), .sw_sel(sw_sel), .stat_sel(stat_sel),
    .sw_wr(sw_wr), .sw_off(sw_off), .sw_rdata(sw_rdata)
  );

  function automatic logic [7:0] rom_of(input logic [15:0] a);
    return a[7:0] ^ a[15:8];
  endfunction

  always_ff @(posedge clk) rom_rdata <= rom_of(rom_addr);

  // {offset, write, expected bank2, expected read-enable}
  localparam logic [6:0] VEC [10] = '{
    {4'h0, 1'b0, 1'b1, 1'b1},
    {4'h8, 1'b0, 1'b0, 1'b1},
    {4'hA, 1'b0, 1'b0, 1'b0},
    {4'h6, 1'b1, 1'b1, 1'b0},
    {4'h3, 1'b1, 1'b1, 1'b1},
    {4'hD, 1'b0, 1'b0, 1'b0},
    {4'hF, 1'b1, 1'b0, 1'b1},
    {4'h4, 1'b0, 1'b1, 1'b1},
    {4'hE, 1'b1, 1'b0, 1'b0},
    {4'h1, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic sw(input logic [3:0] off, input logic wr, output logic [7:0] d);
    @(negedge clk); sw_sel = 1; sw_off = off; sw_wr = wr;
    #1 d = sw_rdata;
    @(negedge clk); sw_sel = 0; sw_wr = 0;
  endtask

  task automatic swq(input logic [3:0] off, input logic wr);
    logic [7:0] d;
    sw(off, wr, d);
  endtask

  task automatic stat(input logic [3:0] off, output logic [7:0] d);
    @(negedge clk); stat_sel = 1; sw_off = off;
    #1 d = sw_rdata;
    @(negedge clk); stat_sel = 0;
  endtask

  task automatic cpu_read(input logic [15:0] a, output logic [7:0] d, output logic v);
    @(negedge clk); cpu_req = 1; cpu_wr = 0; cpu_addr = a;
    @(negedge clk); v = cpu_rvalid; d = cpu_rdata; cpu_req = 0;
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] w, output logic v);
    @(negedge clk); cpu_req = 1; cpu_wr = 1; cpu_addr = a; cpu_wdata = w;
    @(negedge clk); v = cpu_rvalid; cpu_req = 0; cpu_wr = 0;
  endtask

  task automatic wr_ok(input logic [15:0] a, input logic [7:0] w);
    logic v;
    cpu_write(a, w, v);
  endtask

  task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
    logic [7:0] d; logic v;
    cpu_read(a, d, v);
    chk({tag, " valid"}, {7'b0, v}, 8'h01);
    chk(tag, d, exp);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    logic [7:0] d; logic v;
    repeat (3) @(negedge clk);
    rst_n = 1;

    stat(4'h1, d); chk("R1 bank status after reset", d, 8'h00);
    stat(4'h2, d); chk("R1 read status after reset", d, 8'h00);
    rd_chk("R1 rom visible after reset", 16'hD000, rom_of(16'hD000));
    cpu_read(16'h1234, d, v); chk("R10 no valid below overlay", {7'b0, v}, 8'h00);

    for (int i = 0; i < 10; i++) begin
      sw(VEC[i][6:3], VEC[i][2], d);
      chk("R6 switch returns zero", d, 8'h00);
      stat(4'h1, d); chk("R2 bank flag", d, VEC[i][1] ? 8'h80 : 8'h00);
      stat(4'h2, d); chk("R3 R4 read flag", d, VEC[i][0] ? 8'h80 : 8'h00);
    end

    swq(4'h8, 0); swq(4'hB, 0); swq(4'hB, 0);
    wr_ok(16'hD010, 8'h11); wr_ok(16'hD030, 8'h55); wr_ok(16'hD040, 8'h01);
    rd_chk("R4 double read arms writes", 16'hD010, 8'h11);

    swq(4'h3, 0);
    wr_ok(16'hD010, 8'h22);
    rd_chk("R7 bank 2 data", 16'hD010, 8'h22);
    swq(4'hB, 0);
    rd_chk("R7 bank 1 isolated from bank 2", 16'hD010, 8'h11);
    wr_ok(16'hE020, 8'h33);
    swq(4'h3, 0);
    rd_chk("R8 common region across banks", 16'hE020, 8'h33);

    swq(4'hB, 1);
    wr_ok(16'hD040, 8'h66);
    rd_chk("R5 switch write keeps write enable", 16'hD040, 8'h66);

    swq(4'hB, 0); swq(4'hB, 1); swq(4'hB, 0);
    wr_ok(16'hD030, 8'h44);
    rd_chk("R5 switch write disarms", 16'hD030, 8'h55);

    swq(4'hB, 0); swq(4'hA, 0); swq(4'hB, 0);
    wr_ok(16'hD030, 8'h77);
    rd_chk("R3 code 10 disarms", 16'hD030, 8'h55);

    swq(4'h9, 0); swq(4'h9, 0);
    rd_chk("R9 rom when reads disabled", 16'hD030, rom_of(16'hD030));
    cpu_write(16'hD030, 8'h88, v);
    chk("R10 no valid on write", {7'b0, v}, 8'h00);
    swq(4'hB, 0);
    rd_chk("R9 write reaches ram with rom reads", 16'hD030, 8'h88);

    swq(4'hA, 0);
    rd_chk("R9 rom in common range", 16'hF012, rom_of(16'hF012));
    stat(4'h5, d); chk("R6 other status offset", d, 8'h00);
    stat(4'h2, d); chk("R6 status after code 10", d, 8'h00);

    done = 1;
    summary();
  end
endmodule